// File: doc/BRIEF.md
# Dual Periodic Tick Divider with Sticky Event Flags

This block holds two free-running 14-bit up-counters that turn slow clock ticks into periodic events for timekeeping and for waking a processor out of a low-power hold state. Both counters live in a single synchronous clock domain. Each one advances only on a cycle in which its tick enable is high. The first counter takes one step per main-oscillator tick. The second counter steps on a 32768 Hz sub-clock tick when the block runs in dual-clock mode. In single-clock mode it steps on every 128th main tick instead, which a free-running 7-bit prescaler produces.

When a counter reaches its event point, a sticky event flag is set. An interrupt request follows that flag only while its interrupt enable is high. A hold-release request follows the same flag only while its hold-release enable is high. Software can clear each flag. Software can also zero the four most significant counter stages of either counter. For the second counter, a period-select bit picks one of two event points:
- the carry out of bit 13, every 16384 ticks (500 ms at 32768 Hz);
- the carry out of bit 11, every 4096 ticks (125 ms at 32768 Hz).

Top module: `pdt_timer_pair`

## Requirements
- R1: While `rst_n` is low at a clock edge, both counters, both event flags, the prescaler and the period select return to 0. All request outputs then read 0.
- R2: Each counter advances by exactly one on a clock edge where its tick is enabled, and holds its value otherwise. From 0x3FFF it wraps to 0x0000.
- R3: Counter 0 raises an event on a tick taken at value 0x3FFF. The event sets `evt_flag_o[0]` at the same edge, and the flag stays at 1 until it is cleared.
- R4: `flag_clr_i[n]` clears event flag n at the edge, unless an event for channel n occurs at that same edge. In that case the flag ends at 1.
- R5: `irq_req_o[n]` equals `evt_flag_o[n] & irq_en_i[n]`, and `hold_rel_o[n]` equals `evt_flag_o[n] & hold_en_i[n]`. Both are combinational from the current inputs.
- R6: `clr_hi_i[n]` forces counter bits 13..10 to 0 at the edge. Bits 9..0 still advance as usual, with the carry out of bit 9 discarded. The event decision for that edge uses the count before the clear.
- R7: With `dual_mode_i` = 1, counter 1 ticks on `sub_tick_i`. With `dual_mode_i` = 0, counter 1 ticks once for every 128 cycles with `main_tick_i` high. That tick is counted from reset and falls on the 128th, 256th, ... such cycle.
- R8: When `psel_we_i` is high, `psel_d_i` is written into the period select, and the new value takes effect from the next edge. With select = 0, counter 1 raises its event on a tick at 0x3FFF (every 16384 ticks). With select = 1, it raises its event on a tick where bits 11..0 are 0xFFF (every 4096 ticks).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| main_tick_i | input | 1 | Main-oscillator tick enable |
| sub_tick_i | input | 1 | 32768 Hz sub-clock tick enable |
| dual_mode_i | input | 1 | 1: counter 1 uses the sub tick; 0: counter 1 uses main/128 |
| psel_we_i | input | 1 | Write strobe for the period select |
| psel_d_i | input | 1 | Period select value (0: 16384 ticks, 1: 4096 ticks) |
| clr_hi_i | input | 2 | Per channel: clear the upper four counter stages |
| flag_clr_i | input | 2 | Per channel: clear the event flag |
| irq_en_i | input | 2 | Per channel: interrupt enable |
| hold_en_i | input | 2 | Per channel: hold-release enable |
| cnt0_o | output | 14 | Counter 0 value |
| cnt1_o | output | 14 | Counter 1 value |
| evt_flag_o | output | 2 | Sticky event flags |
| irq_req_o | output | 2 | Gated interrupt requests |
| hold_rel_o | output | 2 | Gated hold-release requests |

## Verification
The assertions assume that every input changes only between clock edges and is stable at each edge. They also assume that reset is held for at least one edge before counting begins, since all `$past` terms depend on a clean post-reset history. The stimulus drives every input on the falling edge. It mixes dense tick enables with rare upper-stage clears, flag clears and period-select writes, so that wraps, set-versus-clear collisions and clears in the same cycle as a tick all occur. Directed runs then walk each counter to its exact event point: the 4096-tick and 16384-tick periods, the 128-tick prescaler, a clear at 0x3FFF, and an upper-stage clear on a nonzero count.

// File: rtl/pdt_pkg.sv
// Shared sizing for the periodic tick divider pair.
// Assumes: all channels use the same counter width; only the last channel
// has a selectable short period.
package pdt_pkg;
    localparam int CNT_W      = 14;   // counter stages per channel
    localparam int HI_STAGES  = 4;    // stages zeroed by the upper clear
    localparam int LOW_W      = CNT_W - HI_STAGES;
    localparam int FAST_BITS  = 12;   // short period: carry out of bit FAST_BITS-1
    localparam int PRE_W      = 7;    // main/128 prescaler width
    localparam int NCH        = 2;    // channel count
endpackage

// File: rtl/pdt_prescaler.sv
// Free-running prescaler: emits a one-cycle pulse on every 2**W-th
// enabled tick, counted from reset.
// Assumes: tick_i is a synchronous enable sampled at clk.
module pdt_prescaler #(
    parameter int W = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    output logic pulse_o
);
    logic [W-1:0] cnt_q;

    // Count enabled ticks, wrapping at 2**W.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (tick_i) cnt_q <= cnt_q + W'(1);
    end

    // The pulse marks the tick that completes a full prescaler cycle.
    assign pulse_o = tick_i & (&cnt_q);

    // R7: two prescaled pulses can never be adjacent.
    a_r7_pulse_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o);
endmodule

// File: rtl/pdt_counter.sv
// One divider stage: a CNT_W-bit up-counter with an upper-stage clear and
// an event output taken either at full wrap or at the carry out of the
// low FAST_BITS stages.
// Assumes: en_i, clr_hi_i and fast_sel_i are synchronous to clk.
module pdt_counter #(
    parameter int CNT_W     = 14,
    parameter int HI_STAGES = 4,
    parameter int FAST_BITS = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             clr_hi_i,
    input  logic             fast_sel_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             evt_o
);
    localparam int LOW_W = CNT_W - HI_STAGES;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] inc;
    logic [CNT_W-1:0] cnt_d;
    logic             full_hit;
    logic             fast_hit;

    // Next count: increment, then zero the upper stages when clearing.
    always_comb begin
        inc   = cnt_q + CNT_W'(en_i);
        cnt_d = inc;
        if (clr_hi_i) cnt_d = {{HI_STAGES{1'b0}}, inc[LOW_W-1:0]};
    end

    // Counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // Event decision from the pre-clear count.
    assign full_hit = &cnt_q;
    assign fast_hit = &cnt_q[FAST_BITS-1:0];
    assign evt_o    = en_i & (fast_sel_i ? fast_hit : full_hit);
    assign cnt_o    = cnt_q;

    // R2: without a clear the count moves by the tick enable only.
    a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_hi_i |=> cnt_q == CNT_W'($past(cnt_q) + CNT_W'($past(en_i))));
    // R6: upper stages are zero after a clear.
    a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr_hi_i |=> cnt_q[CNT_W-1:LOW_W] == '0);
    // R6: lower stages keep counting through a clear.
    a_r6_lower_kept: assert property (@(posedge clk) disable iff (!rst_n)
        clr_hi_i |=> cnt_q[LOW_W-1:0] ==
            LOW_W'($past(cnt_q[LOW_W-1:0]) + LOW_W'($past(en_i))));
    // R3: a full-period event leaves the counter at zero.
    a_r3_evt_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o && !fast_sel_i |=> cnt_q == '0);
endmodule

// File: rtl/pdt_event.sv
// Sticky event flag with enable-gated interrupt and hold-release requests.
// Assumes: evt_i is a single-cycle strobe; a set beats a clear at the same edge.
module pdt_event (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic flag_clr_i,
    input  logic irq_en_i,
    input  logic hold_en_i,
    output logic flag_o,
    output logic irq_o,
    output logic hold_o
);
    logic flag_q;

    // Flag register: set wins, then clear, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)          flag_q <= 1'b0;
        else if (evt_i)      flag_q <= 1'b1;
        else if (flag_clr_i) flag_q <= 1'b0;
    end

    // Requests follow the flag through their enables.
    assign flag_o = flag_q;
    assign irq_o  = flag_q & irq_en_i;
    assign hold_o = flag_q & hold_en_i;

    // R3: an event always leaves the flag set.
    a_r3_set: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i |=> flag_q);
    // R4: a clear without an event drops the flag.
    a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr_i && !evt_i |=> !flag_q);
    // R3: the flag is sticky with no event and no clear.
    a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_i && !flag_clr_i |=> flag_q == $past(flag_q));
endmodule

// File: rtl/pdt_timer_pair.sv
// Two periodic tick dividers. Channel 0 counts main ticks. Channel 1 counts
// either sub-clock ticks (dual mode) or main ticks divided by 2**PRE_W,
// with a selectable short or long event period.
// Assumes: every input is synchronous to clk; reset is synchronous, active low.
module pdt_timer_pair
    import pdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             main_tick_i,
    input  logic             sub_tick_i,
    input  logic             dual_mode_i,
    input  logic             psel_we_i,
    input  logic             psel_d_i,
    input  logic [NCH-1:0]   clr_hi_i,
    input  logic [NCH-1:0]   flag_clr_i,
    input  logic [NCH-1:0]   irq_en_i,
    input  logic [NCH-1:0]   hold_en_i,
    output logic [CNT_W-1:0] cnt0_o,
    output logic [CNT_W-1:0] cnt1_o,
    output logic [NCH-1:0]   evt_flag_o,
    output logic [NCH-1:0]   irq_req_o,
    output logic [NCH-1:0]   hold_rel_o
);
    logic             psel_q;
    logic             pre_pulse;
    logic [CNT_W-1:0] cnt_w [NCH];
    logic [NCH-1:0]   evt_w;

    // Period select register for the last channel.
    always_ff @(posedge clk) begin
        if (!rst_n)         psel_q <= 1'b0;
        else if (psel_we_i) psel_q <= psel_d_i;
    end

    pdt_prescaler #(.W(PRE_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (main_tick_i),
        .pulse_o (pre_pulse)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic tick;
        logic fast;
        if (g == 0) begin : g_main
            assign tick = main_tick_i;
            assign fast = 1'b0;
        end else begin : g_sub
            assign tick = dual_mode_i ? sub_tick_i : pre_pulse;
            assign fast = psel_q;
        end

        pdt_counter #(
            .CNT_W     (CNT_W),
            .HI_STAGES (HI_STAGES),
            .FAST_BITS (FAST_BITS)
        ) u_cnt (
            .clk        (clk),
            .rst_n      (rst_n),
            .en_i       (tick),
            .clr_hi_i   (clr_hi_i[g]),
            .fast_sel_i (fast),
            .cnt_o      (cnt_w[g]),
            .evt_o      (evt_w[g])
        );

        pdt_event u_evt (
            .clk        (clk),
            .rst_n      (rst_n),
            .evt_i      (evt_w[g]),
            .flag_clr_i (flag_clr_i[g]),
            .irq_en_i   (irq_en_i[g]),
            .hold_en_i  (hold_en_i[g]),
            .flag_o     (evt_flag_o[g]),
            .irq_o      (irq_req_o[g]),
            .hold_o     (hold_rel_o[g])
        );

        // R5: no request without a standing flag.
        a_r5_req_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_req_o[g] || hold_rel_o[g]) |-> evt_flag_o[g]);
    end

    assign cnt0_o = cnt_w[0];
    assign cnt1_o = cnt_w[1];

    // R8: a written select is held from the next edge.
    a_r8_psel_write: assert property (@(posedge clk) disable iff (!rst_n)
        psel_we_i |=> psel_q == $past(psel_d_i));
    // R7: in dual mode counter 1 ignores main ticks.
    a_r7_dual_hold: assert property (@(posedge clk) disable iff (!rst_n)
        dual_mode_i && !sub_tick_i && !clr_hi_i[1] |=> $stable(cnt1_o));
endmodule

// File: tb/pdt_timer_pair_bench.sv
`timescale 1ns/1ps
module pdt_timer_pair_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        main_tick, sub_tick, dual_mode, psel_we, psel_d;
    logic [1:0]  clr_hi, flag_clr, irq_en, hold_en;
    logic [13:0] cnt0, cnt1;
    logic [1:0]  evt_flag, irq_req, hold_rel;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Reference state
    logic [13:0] m_cnt [2];
    logic [1:0]  m_flag;
    logic [6:0]  m_pre;
    logic        m_psel;

    always #2 clk = ~clk;

    pdt_timer_pair u_pdt_timer_pair (
        .clk(clk), .rst_n(rst_n), .main_tick_i(main_tick), .sub_tick_i(sub_tick),
        .dual_mode_i(dual_mode), .psel_we_i(psel_we), .psel_d_i(psel_d),
        .clr_hi_i(clr_hi), .flag_clr_i(flag_clr), .irq_en_i(irq_en),
        .hold_en_i(hold_en), .cnt0_o(cnt0), .cnt1_o(cnt1),
        .evt_flag_o(evt_flag), .irq_req_o(irq_req), .hold_rel_o(hold_rel)
    );

    task automatic chk(input string rq, input string nm, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", rq, nm, got, exp);
        end
    endtask

    // Next count per R2 and R6.
    function automatic logic [13:0] f_next(input logic [13:0] c, input logic t, input logic clr);
        logic [13:0] n;
        n = c + 14'(t);
        if (clr) n[13:10] = 4'd0;
        return n;
    endfunction

    // Event decision per R3 and R8.
    function automatic logic f_evt(input logic [13:0] c, input logic t, input logic fast);
        return t && (fast ? (c[11:0] == 12'hFFF) : (c == 14'h3FFF));
    endfunction

    task automatic model_reset();
        m_cnt[0] = '0; m_cnt[1] = '0; m_flag = '0; m_pre = '0; m_psel = 1'b0;
    endtask

    // One clock: predict, step, compare.
    task automatic cyc();
        logic [13:0] nc [2];
        logic [1:0]  nf;
        logic        t1, e0, e1;
        t1 = dual_mode ? sub_tick : (main_tick && m_pre == 7'h7F);
        e0 = f_evt(m_cnt[0], main_tick, 1'b0);
        e1 = f_evt(m_cnt[1], t1, m_psel);
        nc[0] = f_next(m_cnt[0], main_tick, clr_hi[0]);
        nc[1] = f_next(m_cnt[1], t1, clr_hi[1]);
        nf[0] = e0 ? 1'b1 : (flag_clr[0] ? 1'b0 : m_flag[0]);
        nf[1] = e1 ? 1'b1 : (flag_clr[1] ? 1'b0 : m_flag[1]);
        @(posedge clk);
        #1;
        if (!rst_n) model_reset();
        else begin
            m_cnt[0] = nc[0]; m_cnt[1] = nc[1]; m_flag = nf;
            if (main_tick) m_pre = m_pre + 7'd1;
            if (psel_we) m_psel = psel_d;
        end
        chk("R2", "cnt0", int'(cnt0), int'(m_cnt[0]));
        chk("R7", "cnt1", int'(cnt1), int'(m_cnt[1]));
        chk("R3", "flags", int'(evt_flag), int'(m_flag));
        chk("R5", "irq", int'(irq_req), int'(m_flag & irq_en));
        chk("R5", "hold", int'(hold_rel), int'(m_flag & hold_en));
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        main_tick = 0; sub_tick = 0; dual_mode = 1; psel_we = 0; psel_d = 0;
        clr_hi = 0; flag_clr = 0; irq_en = 0; hold_en = 0;
    endtask

    task automatic do_reset();
        idle_inputs();
        rst_n = 1'b0;
        repeat (3) cyc();
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED));
        model_reset();
        @(negedge clk);
        do_reset();
        // R1: reset state at the ports.
        chk("R1", "cnt0 reset", int'(cnt0), 0);
        chk("R1", "cnt1 reset", int'(cnt1), 0);
        chk("R1", "flags reset", int'(evt_flag), 0);

        // Random mix: dense ticks, rare clears and select writes.
        for (int i = 0; i < 40000; i++) begin
            main_tick = ($urandom % 10) != 0;
            sub_tick  = ($urandom % 2) == 0;
            dual_mode = (i < 30000) ? 1'b1 : (($urandom % 4) != 0);
            clr_hi[0] = ($urandom % 512) == 0;
            clr_hi[1] = ($urandom % 512) == 0;
            flag_clr[0] = ($urandom % 64) == 0;
            flag_clr[1] = ($urandom % 64) == 0;
            psel_we = ($urandom % 2000) == 0;
            psel_d  = $urandom % 2;
            if ($urandom % 16 == 0) irq_en  = 2'($urandom);
            if ($urandom % 16 == 0) hold_en = 2'($urandom);
            cyc();
        end

        // R8: short period gives an event after exactly 4096 sub ticks.
        do_reset();
        psel_we = 1; psel_d = 1; cyc();
        psel_we = 0; sub_tick = 1; irq_en = 2'b10;
        repeat (4095) cyc();
        chk("R8", "flag1 before 4096", int'(evt_flag[1]), 0);
        chk("R8", "cnt1 at 4095", int'(cnt1), 4095);
        cyc();
        chk("R8", "flag1 at 4096", int'(evt_flag[1]), 1);
        chk("R5", "irq1 gated on", int'(irq_req[1]), 1);

        // R7: single-clock mode divides main ticks by 128.
        do_reset();
        dual_mode = 0; main_tick = 1; sub_tick = 1;
        repeat (1279) cyc();
        chk("R7", "cnt1 after 1279 main", int'(cnt1), 9);
        cyc();
        chk("R7", "cnt1 after 1280 main", int'(cnt1), 10);

        // R6: upper clear on 0xBB8 with a tick keeps the low ten bits counting.
        do_reset();
        main_tick = 1;
        repeat (3000) cyc();
        chk("R2", "cnt0 at 3000", int'(cnt0), 3000);
        clr_hi[0] = 1; cyc(); clr_hi[0] = 0;
        chk("R6", "cnt0 after upper clear", int'(cnt0), 'h3B9);

        // R4: event and clear at the same edge leave the flag set.
        do_reset();
        main_tick = 1; hold_en = 2'b01;
        repeat (16383) cyc();
        chk("R3", "cnt0 at top", int'(cnt0), 'h3FFF);
        chk("R3", "flag0 before wrap", int'(evt_flag[0]), 0);
        flag_clr[0] = 1; cyc();
        chk("R4", "flag0 set wins", int'(evt_flag[0]), 1);
        chk("R5", "hold0 gated on", int'(hold_rel[0]), 1);
        chk("R5", "irq0 gated off", int'(irq_req[0]), 0);
        main_tick = 0; cyc();
        chk("R4", "flag0 cleared", int'(evt_flag[0]), 0);
        flag_clr[0] = 0; cyc();
        chk("R3", "flag0 stays clear", int'(evt_flag[0]), 0);

        finish_run();
    end
endmodule